// File: doc/BRIEF.md
# Display Controller Command Parser

This block sits behind a serial slave front end of a small greyscale display controller. It takes one byte per valid strobe, together with a command/data select line. When the select line is low, the bytes are commands. The block collects an opcode and the number of parameter bytes that opcode needs. When the last parameter arrives, it executes the command. Supported commands load the column window, the row window, the address-remap register and the contrast register. Analog, timing and power opcodes are accepted, their parameters are consumed, and they have no effect. Unknown opcodes raise a one-cycle error pulse and are dropped.

When the select line is high, each byte goes to the framebuffer write path. The byte is presented with the current column and row pointers. The pointers then step through the programmed window, either column first or row first. Bit 2 of the remap register picks the order. The host therefore programs a window once and then streams pixel bytes into it.

Top module: `dcp_cmd_parser`

## Requirements
- R1: After reset, the column window is 0..NUM_COLS-1 and the row window is 0..NUM_ROWS-1. Both address pointers are 0. Remap and contrast are 0. `cmd_err` and `fb_we` are low.
- R2: A byte with `in_dc`=1 is written to the framebuffer one cycle after it is strobed. In that cycle `fb_we`=1, `fb_data` is the byte, and `fb_col`/`fb_row` hold the pointer values from before the write.
- R3: With remap bit 2 clear, each data byte increments the column pointer. If the column passes the column end, it reloads the column start and the row pointer increments. If the row passes the row end, it reloads the row start.
- R4: With remap bit 2 set, the roles swap. The row pointer increments first and wraps to the row start. The column pointer increments only on a row wrap, and wraps to the column start.
- R5: Opcode 0x15 takes two parameter bytes. The column start and column pointer become p0 mod NUM_COLS, and the column end becomes p1 mod NUM_COLS. Nothing changes before the second parameter arrives.
- R6: Opcode 0x75 takes two parameter bytes. The row start and row pointer become p0 mod NUM_ROWS, and the row end becomes p1 mod NUM_ROWS.
- R7: Opcode 0xA0 loads its single parameter into the remap register. Opcode 0x81 loads its single parameter into the contrast register.
- R8: The following opcodes take no parameters and have no effect: 0xA4-0xA7, 0xAE, 0xAF, 0xE3 and 0xFF. The following opcodes consume exactly one parameter byte and have no effect: 0xA1, 0xA2, 0xA8, 0xAD, 0xB1-0xB3, 0xBC, 0xBE and 0xBF.
- R9: Any other opcode pulses `cmd_err` high for exactly the cycle after it is strobed. The opcode is dropped, and the next command byte is treated as an opcode.
- R10: Data bytes that arrive while a command is partly collected are written to the framebuffer and do not disturb the collection. Command bytes never raise `fb_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Byte strobe from the serial front end |
| in_dc | input | 1 | 1 = data byte, 0 = command byte |
| in_byte | input | DATA_W | Received byte |
| fb_we | output | 1 | Framebuffer write strobe |
| fb_data | output | DATA_W | Framebuffer write byte |
| fb_col | output | clog2(NUM_COLS) | Framebuffer write column |
| fb_row | output | clog2(NUM_ROWS) | Framebuffer write row |
| win_col_start | output | clog2(NUM_COLS) | Column window start |
| win_col_end | output | clog2(NUM_COLS) | Column window end |
| win_row_start | output | clog2(NUM_ROWS) | Row window start |
| win_row_end | output | clog2(NUM_ROWS) | Row window end |
| remap | output | DATA_W | Remap register |
| contrast | output | DATA_W | Contrast register |
| cmd_err | output | 1 | One-cycle unknown-opcode pulse |

## Verification
Every one of the 256 opcode values is sent, followed by its expected number of filler bytes and then a contrast probe. This separates unknown opcodes from known ones and catches any parameter count that is off by one. The column and row commands are swept over all 256 values of the first parameter, which exposes any error in the two modulo reductions. Pixel streams are written into windows in both increment orders, including windows that touch the array edge and windows whose start lies past their end. Each write address is compared with an arithmetic model of the pointers. A command split by interleaved data bytes shows that collection and writes are independent.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  typedef enum logic [2:0] {
    K_UNKNOWN,
    K_IGNORE,
    K_COL,
    K_ROW,
    K_REMAP,
    K_CONTRAST
  } op_kind_e;

  typedef struct packed {
    op_kind_e   kind;
    logic [1:0] nparam;
  } op_info_t;

  localparam logic [7:0] OP_COL_WIN  = 8'h15;
  localparam logic [7:0] OP_ROW_WIN  = 8'h75;
  localparam logic [7:0] OP_CONTRAST = 8'h81;
  localparam logic [7:0] OP_REMAP    = 8'hA0;
endpackage

// File: rtl/dcp_opcode_decode.sv
module dcp_opcode_decode
  import dcp_pkg::*;
(
  input  logic [7:0] op,
  output op_info_t   info
);
  always_comb begin
    unique case (op)
      OP_COL_WIN:  info = '{kind: K_COL,      nparam: 2'd2};
      OP_ROW_WIN:  info = '{kind: K_ROW,      nparam: 2'd2};
      OP_REMAP:    info = '{kind: K_REMAP,    nparam: 2'd1};
      OP_CONTRAST: info = '{kind: K_CONTRAST, nparam: 2'd1};
      8'hA1, 8'hA2, 8'hA8, 8'hAD, 8'hB1, 8'hB2, 8'hB3,
      8'hBC, 8'hBE, 8'hBF:
        info = '{kind: K_IGNORE, nparam: 2'd1};
      8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'hAE, 8'hAF, 8'hE3, 8'hFF:
        info = '{kind: K_IGNORE, nparam: 2'd0};
      default:
        info = '{kind: K_UNKNOWN, nparam: 2'd0};
    endcase
  end
endmodule

// File: rtl/dcp_cmd_collect.sv
module dcp_cmd_collect
  import dcp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PBUF_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_byte,
  input  op_info_t          live_info,
  output logic              exec_valid,
  output op_kind_e          exec_kind,
  output logic [DATA_W-1:0] exec_p0,
  output logic [DATA_W-1:0] exec_p1,
  output logic              cmd_err
);
  localparam int CNT_W = (PBUF_DEPTH > 1) ? $clog2(PBUF_DEPTH) : 1;

  logic              busy_q;
  op_kind_e          kind_q;
  logic [1:0]        need_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] pbuf [PBUF_DEPTH];
  logic              last_param;

  assign last_param = ((CNT_W+1)'(cnt_q) + (CNT_W+1)'(1)) == (CNT_W+1)'(need_q);

  always_comb begin
    exec_valid = 1'b0;
    exec_kind  = kind_q;
    exec_p0    = (cnt_q == '0) ? cmd_byte : pbuf[0];
    exec_p1    = cmd_byte;
    if (cmd_valid) begin
      if (!busy_q) begin
        if (live_info.kind != K_UNKNOWN && live_info.nparam == 2'd0) begin
          exec_valid = 1'b1;
          exec_kind  = live_info.kind;
        end
      end else if (last_param) begin
        exec_valid = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      kind_q  <= K_UNKNOWN;
      need_q  <= 2'd0;
      cnt_q   <= '0;
      cmd_err <= 1'b0;
    end else begin
      cmd_err <= 1'b0;
      if (cmd_valid) begin
        if (!busy_q) begin
          if (live_info.kind == K_UNKNOWN) begin
            cmd_err <= 1'b1;
          end else if (live_info.nparam != 2'd0) begin
            busy_q <= 1'b1;
            kind_q <= live_info.kind;
            need_q <= live_info.nparam;
            cnt_q  <= '0;
          end
        end else if (last_param) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else if (cnt_q != CNT_W'(PBUF_DEPTH-1)) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cmd_valid && busy_q) pbuf[cnt_q] <= cmd_byte;
  end

  a_r9_err_source: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> $past(cmd_valid && !busy_q));
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> ((CNT_W+1)'(cnt_q) < (CNT_W+1)'(need_q)));
endmodule

// File: rtl/dcp_window.sv
module dcp_window
  import dcp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_COLS = 64,
  parameter int NUM_ROWS = 80
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        exec_valid,
  input  op_kind_e                    exec_kind,
  input  logic [DATA_W-1:0]           exec_p0,
  input  logic [DATA_W-1:0]           exec_p1,
  input  logic                        data_valid,
  input  logic [DATA_W-1:0]           data_byte,
  output logic                        fb_we,
  output logic [DATA_W-1:0]           fb_data,
  output logic [$clog2(NUM_COLS)-1:0] fb_col,
  output logic [$clog2(NUM_ROWS)-1:0] fb_row,
  output logic [$clog2(NUM_COLS)-1:0] col_start_q,
  output logic [$clog2(NUM_COLS)-1:0] col_end_q,
  output logic [$clog2(NUM_ROWS)-1:0] row_start_q,
  output logic [$clog2(NUM_ROWS)-1:0] row_end_q,
  output logic [DATA_W-1:0]           remap_q,
  output logic [DATA_W-1:0]           contrast_q
);
  localparam int COL_W    = $clog2(NUM_COLS);
  localparam int ROW_W    = $clog2(NUM_ROWS);
  localparam int VERT_BIT = 2;

  logic [COL_W-1:0] col_ptr, col_nxt;
  logic [ROW_W-1:0] row_ptr, row_nxt;
  logic [COL_W:0]   col_inc;
  logic [ROW_W:0]   row_inc;
  logic             col_wrap, row_wrap;
  logic [COL_W-1:0] col_step;
  logic [ROW_W-1:0] row_step;

  assign col_inc  = {1'b0, col_ptr} + 1'b1;
  assign row_inc  = {1'b0, row_ptr} + 1'b1;
  assign col_wrap = col_inc > {1'b0, col_end_q};
  assign row_wrap = row_inc > {1'b0, row_end_q};
  assign col_step = col_wrap ? col_start_q : col_inc[COL_W-1:0];
  assign row_step = row_wrap ? row_start_q : row_inc[ROW_W-1:0];

  always_comb begin
    if (remap_q[VERT_BIT]) begin
      row_nxt = row_step;
      col_nxt = row_wrap ? col_step : col_ptr;
    end else begin
      col_nxt = col_step;
      row_nxt = col_wrap ? row_step : row_ptr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      col_ptr     <= '0;
      row_ptr     <= '0;
      col_start_q <= '0;
      col_end_q   <= COL_W'(NUM_COLS-1);
      row_start_q <= '0;
      row_end_q   <= ROW_W'(NUM_ROWS-1);
      remap_q     <= '0;
      contrast_q  <= '0;
      fb_we       <= 1'b0;
      fb_data     <= '0;
      fb_col      <= '0;
      fb_row      <= '0;
    end else begin
      fb_we <= 1'b0;
      if (data_valid) begin
        fb_we   <= 1'b1;
        fb_data <= data_byte;
        fb_col  <= col_ptr;
        fb_row  <= row_ptr;
        col_ptr <= col_nxt;
        row_ptr <= row_nxt;
      end else if (exec_valid) begin
        case (exec_kind)
          K_COL: begin
            col_ptr     <= COL_W'(exec_p0 % NUM_COLS);
            col_start_q <= COL_W'(exec_p0 % NUM_COLS);
            col_end_q   <= COL_W'(exec_p1 % NUM_COLS);
          end
          K_ROW: begin
            row_ptr     <= ROW_W'(exec_p0 % NUM_ROWS);
            row_start_q <= ROW_W'(exec_p0 % NUM_ROWS);
            row_end_q   <= ROW_W'(exec_p1 % NUM_ROWS);
          end
          K_REMAP:    remap_q    <= exec_p0;
          K_CONTRAST: contrast_q <= exec_p0;
          default: ;
        endcase
      end
    end
  end

  a_r2_we_from_data: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> $past(data_valid));
  a_r10_we_not_cmd: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> $past(!exec_valid));
  a_r3_col_range: assert property (@(posedge clk) disable iff (rst)
    (COL_W+1)'(col_ptr) < (COL_W+1)'(NUM_COLS));
  a_r6_row_range: assert property (@(posedge clk) disable iff (rst)
    (ROW_W+1)'(row_ptr) < (ROW_W+1)'(NUM_ROWS));
  a_r7_remap_by_cmd: assert property (@(posedge clk) disable iff (rst)
    !$stable(remap_q) |-> $past(exec_valid && exec_kind == K_REMAP));
endmodule

// File: rtl/dcp_cmd_parser.sv
module dcp_cmd_parser
  import dcp_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int NUM_COLS   = 64,
  parameter int NUM_ROWS   = 80,
  parameter int PBUF_DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic                        in_dc,
  input  logic [DATA_W-1:0]           in_byte,
  output logic                        fb_we,
  output logic [DATA_W-1:0]           fb_data,
  output logic [$clog2(NUM_COLS)-1:0] fb_col,
  output logic [$clog2(NUM_ROWS)-1:0] fb_row,
  output logic [$clog2(NUM_COLS)-1:0] win_col_start,
  output logic [$clog2(NUM_COLS)-1:0] win_col_end,
  output logic [$clog2(NUM_ROWS)-1:0] win_row_start,
  output logic [$clog2(NUM_ROWS)-1:0] win_row_end,
  output logic [DATA_W-1:0]           remap,
  output logic [DATA_W-1:0]           contrast,
  output logic                        cmd_err
);
  logic              cmd_valid, data_valid;
  op_info_t          live_info;
  logic              exec_valid;
  op_kind_e          exec_kind;
  logic [DATA_W-1:0] exec_p0, exec_p1;

  assign cmd_valid  = in_valid && !in_dc;
  assign data_valid = in_valid && in_dc;

  dcp_opcode_decode u_dec (
    .op   (in_byte[7:0]),
    .info (live_info)
  );

  dcp_cmd_collect #(
    .DATA_W     (DATA_W),
    .PBUF_DEPTH (PBUF_DEPTH)
  ) u_collect (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_byte   (in_byte),
    .live_info  (live_info),
    .exec_valid (exec_valid),
    .exec_kind  (exec_kind),
    .exec_p0    (exec_p0),
    .exec_p1    (exec_p1),
    .cmd_err    (cmd_err)
  );

  dcp_window #(
    .DATA_W   (DATA_W),
    .NUM_COLS (NUM_COLS),
    .NUM_ROWS (NUM_ROWS)
  ) u_window (
    .clk         (clk),
    .rst         (rst),
    .exec_valid  (exec_valid),
    .exec_kind   (exec_kind),
    .exec_p0     (exec_p0),
    .exec_p1     (exec_p1),
    .data_valid  (data_valid),
    .data_byte   (in_byte),
    .fb_we       (fb_we),
    .fb_data     (fb_data),
    .fb_col      (fb_col),
    .fb_row      (fb_row),
    .col_start_q (win_col_start),
    .col_end_q   (win_col_end),
    .row_start_q (win_row_start),
    .row_end_q   (win_row_end),
    .remap_q     (remap),
    .contrast_q  (contrast)
  );
endmodule

// File: tb/dcp_cmd_parser_tb.sv
module dcp_cmd_parser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL = 64;
  localparam int NROW = 80;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_dc = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       fb_we, cmd_err;
  logic [7:0] fb_data, remap, contrast;
  logic [5:0] fb_col, win_col_start, win_col_end;
  logic [6:0] fb_row, win_row_start, win_row_end;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int ecs, ece, ers, ere, ecp, erp, eremap;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcp_cmd_parser u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_dc(in_dc), .in_byte(in_byte),
    .fb_we(fb_we), .fb_data(fb_data), .fb_col(fb_col), .fb_row(fb_row),
    .win_col_start(win_col_start), .win_col_end(win_col_end),
    .win_row_start(win_row_start), .win_row_end(win_row_end),
    .remap(remap), .contrast(contrast), .cmd_err(cmd_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic dc, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_dc = dc; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic int nparam_of(input logic [7:0] op);
    case (op)
      8'hA4, 8'hA5, 8'hA6, 8'hA7, 8'hAE, 8'hAF, 8'hE3, 8'hFF: return 0;
      8'h81, 8'hA0, 8'hA1, 8'hA2, 8'hA8, 8'hAD, 8'hB1, 8'hB2, 8'hB3,
      8'hBC, 8'hBE, 8'hBF: return 1;
      8'h15, 8'h75: return 2;
      default: return -1;
    endcase
  endfunction

  task automatic check_win(input string req);
    chk(req, win_col_start, ecs); chk(req, win_col_end, ece);
    chk(req, win_row_start, ers); chk(req, win_row_end, ere);
    chk(req, remap, eremap);
  endtask

  task automatic set_cols(input int a, input int b);
    send(0, 8'h15); send(0, a[7:0]);
    chk("R5 no early update", win_col_start, ecs);
    send(0, b[7:0]);
    chk("R10 cmd no write", fb_we, 0);
    ecs = a % NCOL; ecp = ecs; ece = b % NCOL;
    chk("R5 col start", win_col_start, ecs);
    chk("R5 col end", win_col_end, ece);
  endtask

  task automatic set_rows(input int a, input int b);
    send(0, 8'h75); send(0, a[7:0]); send(0, b[7:0]);
    ers = a % NROW; erp = ers; ere = b % NROW;
    chk("R6 row start", win_row_start, ers);
    chk("R6 row end", win_row_end, ere);
  endtask

  task automatic set_remap(input int v);
    send(0, 8'hA0); send(0, v[7:0]);
    eremap = v;
    chk("R7 remap", remap, v);
  endtask

  task automatic advance();
    int ci, ri;
    ci = ecp + 1; ri = erp + 1;
    if (eremap[2]) begin
      if (ri > ere) begin
        erp = ers;
        ecp = (ci > ece) ? ecs : ci;
      end else erp = ri;
    end else begin
      if (ci > ece) begin
        ecp = ecs;
        erp = (ri > ere) ? ers : ri;
      end else ecp = ci;
    end
  endtask

  task automatic write_px(input string req, input logic [7:0] b);
    send(1, b);
    chk({req, " we"}, fb_we, 1);
    chk({req, " data"}, fb_data, b);
    chk({req, " col"}, fb_col, ecp);
    chk({req, " row"}, fb_row, erp);
    advance();
  endtask

  initial begin
    ecs = 0; ece = NCOL-1; ers = 0; ere = NROW-1; ecp = 0; erp = 0; eremap = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_win("R1 reset");
    chk("R1 contrast", contrast, 0);
    chk("R1 err", cmd_err, 0);
    chk("R1 we", fb_we, 0);
    write_px("R2 first write", 8'h5C);
    @(negedge clk);
    chk("R2 we one cycle", fb_we, 0);

    // R5 / R6 modulo sweeps
    for (int p = 0; p < 256; p++) set_cols(p, 255 - p);
    for (int p = 0; p < 256; p++) set_rows(p, (p * 7 + 3) % 256);

    // R3 horizontal order across array edges
    set_remap(0);
    set_cols(61, 63); set_rows(78, 79);
    for (int i = 0; i < 14; i++) write_px("R3 horiz", 8'(i * 17));
    set_cols(10, 5); set_rows(3, 6);
    for (int i = 0; i < 9; i++) write_px("R3 start past end", 8'(i + 1));

    // R4 vertical order
    set_remap(8'h04);
    set_cols(62, 63); set_rows(5, 7);
    for (int i = 0; i < 13; i++) write_px("R4 vert", 8'(255 - i));
    set_cols(0, 63); set_rows(77, 79);
    for (int i = 0; i < 7; i++) write_px("R4 vert full", 8'(i));

    // R7 contrast
    send(0, 8'h81); send(0, 8'hC3);
    chk("R7 contrast", contrast, 8'hC3);

    // R8 / R9 all opcodes with filler and a contrast probe
    for (int op = 0; op < 256; op++) begin
      int n;
      n = nparam_of(8'(op));
      send(0, 8'(op));
      chk(n < 0 ? "R9 err on unknown" : "R8 no err on known", cmd_err, (n < 0) ? 1 : 0);
      for (int k = 0; k < n; k++) send(0, 8'h15);
      if (op == 8'h15) begin ecs = 8'h15 % NCOL; ece = ecs; ecp = ecs; end
      if (op == 8'h75) begin ers = 8'h15 % NROW; ere = ers; erp = ers; end
      if (op == 8'hA0) eremap = 8'h15;
      check_win(n < 0 ? "R9 dropped" : "R8 no side effect");
      send(0, 8'h81); send(0, 8'(op ^ 8'hA5));
      chk("R8 R9 parser realigned", contrast, op ^ 8'hA5);
    end

    // R9 pulse width
    send(0, 8'h84);
    chk("R9 err pulse", cmd_err, 1);
    @(negedge clk);
    chk("R9 err drops", cmd_err, 0);

    // R10 interleaved data during collection
    set_remap(0);
    set_cols(0, 63); set_rows(0, 79);
    send(0, 8'h15);
    write_px("R10 interleave", 8'hAA);
    send(0, 8'd3);
    write_px("R10 interleave", 8'hBB);
    send(0, 8'd9);
    ecs = 3; ece = 9; ecp = 3;
    chk("R10 col start", win_col_start, 3);
    chk("R10 col end", win_col_end, 9);
    write_px("R10 after", 8'hCC);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule